// File: doc/BRIEF.md
# SDRAM Initialization Command Issuer

This block sits between a host memory port and the SDRAM command pins and lets software turn the next memory access into a chosen SDRAM command. Software writes a 3-bit mode value. The value arms a command but emits nothing by itself. The next host access to the memory space fires the armed command, whether that access is a read or a write. The command drives chip-select, row strobe, column strobe, write-enable, address and bank for exactly one cycle, and the access is acknowledged in that same cycle. In normal mode the host request, direction and address go straight through to a downstream access engine, and the engine's acknowledge comes straight back.

After each forced command the host is held off for a programmable number of cycles. For the two mode-register commands, the mode word comes from the address bits of the triggering access. The block tracks whether all banks are known to be closed, and it flags an auto-refresh fired while a row may still be open. The deep power-down command parks the device with clock-enable low until software selects another mode.

The controller has four states. `ST_IDLE` forwards traffic or waits for an access. `ST_FIRE` drives the command for one cycle. `ST_HOLD` is the hold-off window. `ST_DOWN` is deep power-down. The transitions are:
- `ST_IDLE`→`ST_FIRE`: an access arrives while a forced mode is set.
- `ST_FIRE`→`ST_DOWN`: the command fired was deep power-down.
- `ST_FIRE`→`ST_IDLE`: the hold-off count is zero.
- `ST_FIRE`→`ST_HOLD`: the hold-off count is non-zero.
- `ST_HOLD`→`ST_IDLE`: the last hold-off cycle ends.
- `ST_DOWN`→`ST_IDLE`: software writes a mode other than 6 or 7.

Top module: `sdram_cmd_issuer`

## Requirements
- R1: After reset the mode is normal (0). In this state `sdr_cs_n`=1, `sdr_cke`=1, and `host_ack`, `eng_req` and `refresh_err` are all 0 while no request is present.
- R2: In mode 0 the pass-through is combinational. `eng_req` equals `host_req`, `eng_we` equals `host_we`, `eng_addr` equals `host_addr`, and `host_ack` equals `eng_ack` while a request is present. The SDRAM pins stay deselected.
- R3: In modes 1–5 a host access of either direction fires the command. One cycle after the access is sampled, the pins {cs_n,ras_n,cas_n,we_n} show the command for exactly one cycle, with `host_ack`=1 in that cycle. The pin values per mode are: mode 1 = 0111, mode 2 = 0010, mode 3 = 0000, mode 4 = 0001, mode 5 = 0000.
- R4: Precharge-all (mode 2) drives address bit 10 high, all other address bits 0, and bank 0. No-op (mode 1) and auto-refresh (mode 4) drive address 0 and bank 0.
- R5: Mode 3 drives `host_addr[12:0]` on `sdr_addr` with bank 0. Mode 5 drives `host_addr[12:0]` on `sdr_addr` and `host_addr[14:13]` on `sdr_ba`.
- R6: Writing a mode emits no command. A mode stays armed, so every later access fires it again until a new mode is written.
- R7: A mode write of value 7 is ignored, and the previous mode keeps its effect.
- R8: `refresh_err` is high during the auto-refresh command cycle if no precharge-all has fired since reset or since the last completed pass-through handshake. Otherwise it is 0.
- R9: After a forced command, with hold-off count g on `gap_cycles`, no access is served for g cycles. The acknowledges of two back-to-back forced accesses are g+2 cycles apart.
- R10: An access in mode 6 drives 0110 for one cycle with `sdr_cke`=1, and `sdr_cke` is 0 from the next cycle. While the device is down, accesses are acknowledged in their own cycle with the pins deselected, and mode writes of 6 or 7 change nothing. A mode write of any other value raises `sdr_cke` on the next cycle and returns the block to service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode_wr_en | input | 1 | Mode write strobe |
| mode_wr_data | input | 3 | Mode value to arm |
| gap_cycles | input | GAP_W | Hold-off cycles after a forced command |
| host_req | input | 1 | Host access request, held until acknowledged |
| host_we | input | 1 | Host access direction (1 = write) |
| host_addr | input | HA_W | Host access address |
| host_ack | output | 1 | Host access acknowledge |
| eng_req | output | 1 | Request to the downstream access engine |
| eng_we | output | 1 | Direction to the access engine |
| eng_addr | output | HA_W | Address to the access engine |
| eng_ack | input | 1 | Acknowledge from the access engine |
| sdr_cs_n | output | 1 | SDRAM chip select, active low |
| sdr_ras_n | output | 1 | SDRAM row strobe, active low |
| sdr_cas_n | output | 1 | SDRAM column strobe, active low |
| sdr_we_n | output | 1 | SDRAM write enable, active low |
| sdr_addr | output | SA_W | SDRAM address bus |
| sdr_ba | output | BA_W | SDRAM bank address |
| sdr_cke | output | 1 | SDRAM clock enable |
| refresh_err | output | 1 | Auto-refresh fired with banks possibly open |

## Verification
The pass-through results are combinational, so they are checked a moment after the inputs change, in the same half cycle. A forced command, its acknowledge and its error flag appear one edge after the access is sampled. The bench raises the request on a falling edge and samples on the next falling edge, then drops the request there. Clock-enable falls one edge after the power-down command, and rises one edge after the mode write that exits. The hold-off is measured by counting falling edges between two acknowledges and comparing the count with g+2 for every count from 0 to 15.

// File: rtl/sci_pkg.sv
package sci_pkg;

    typedef enum logic [2:0] {
        MD_NORMAL   = 3'd0,
        MD_NOP      = 3'd1,
        MD_PRE_ALL  = 3'd2,
        MD_LOAD_MR  = 3'd3,
        MD_AUTO_REF = 3'd4,
        MD_LOAD_EMR = 3'd5,
        MD_DEEP_PD  = 3'd6,
        MD_RSVD     = 3'd7
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FIRE,
        ST_HOLD,
        ST_DOWN
    } state_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } pins_t;

    localparam pins_t PINS_DESEL = pins_t'(4'b1111);
    localparam pins_t PINS_NOP   = pins_t'(4'b0111);
    localparam pins_t PINS_PRE   = pins_t'(4'b0010);
    localparam pins_t PINS_REF   = pins_t'(4'b0001);
    localparam pins_t PINS_MRS   = pins_t'(4'b0000);
    localparam pins_t PINS_DPD   = pins_t'(4'b0110);

endpackage

// File: rtl/sci_mode_reg.sv
module sci_mode_reg
    import sci_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] wr_data,
    output mode_e      mode
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode <= MD_NORMAL;
        end else if (wr_en && (wr_data != MD_RSVD)) begin
            mode <= mode_e'(wr_data);
        end
    end

    AST_RSVD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data == 3'd7) |=> $stable(mode)); // R7

endmodule

// File: rtl/sci_cmd_decode.sv
module sci_cmd_decode
    import sci_pkg::*;
#(
    parameter int SA_W = 13,
    parameter int BA_W = 2,
    localparam int MW_W = SA_W + BA_W,
    localparam int PRE_BIT = 10
) (
    input  mode_e            mode,
    input  logic [MW_W-1:0]  mode_word,
    output pins_t            pins,
    output logic [SA_W-1:0]  addr,
    output logic [BA_W-1:0]  ba
);

    always_comb begin
        pins = PINS_DESEL;
        addr = '0;
        ba   = '0;
        unique case (mode)
            MD_NOP: begin
                pins = PINS_NOP;
            end
            MD_PRE_ALL: begin
                pins = PINS_PRE;
                addr[PRE_BIT] = 1'b1;
            end
            MD_LOAD_MR: begin
                pins = PINS_MRS;
                addr = mode_word[SA_W-1:0];
            end
            MD_AUTO_REF: begin
                pins = PINS_REF;
            end
            MD_LOAD_EMR: begin
                pins = PINS_MRS;
                addr = mode_word[SA_W-1:0];
                ba   = mode_word[MW_W-1:SA_W];
            end
            MD_DEEP_PD: begin
                pins = PINS_DPD;
            end
            default: begin
                pins = PINS_DESEL;
            end
        endcase
    end

endmodule

// File: rtl/sci_gap_timer.sv
module sci_gap_timer #(
    parameter int GAP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [GAP_W-1:0] load_val,
    output logic             last
);

    logic [GAP_W-1:0] count;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (count != '0) begin
            count <= count - 1'b1;
        end
    end

    assign last = (count == {{(GAP_W-1){1'b0}}, 1'b1});

    AST_GAP_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && count == '0) |=> (count == '0)); // R9

endmodule

// File: rtl/sdram_cmd_issuer.sv
module sdram_cmd_issuer
    import sci_pkg::*;
#(
    parameter int HA_W  = 16,
    parameter int SA_W  = 13,
    parameter int BA_W  = 2,
    parameter int GAP_W = 4,
    localparam int MW_W = SA_W + BA_W,
    localparam int PRE_BIT = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_wr_en,
    input  logic [2:0]       mode_wr_data,
    input  logic [GAP_W-1:0] gap_cycles,
    input  logic             host_req,
    input  logic             host_we,
    input  logic [HA_W-1:0]  host_addr,
    output logic             host_ack,
    output logic             eng_req,
    output logic             eng_we,
    output logic [HA_W-1:0]  eng_addr,
    input  logic             eng_ack,
    output logic             sdr_cs_n,
    output logic             sdr_ras_n,
    output logic             sdr_cas_n,
    output logic             sdr_we_n,
    output logic [SA_W-1:0]  sdr_addr,
    output logic [BA_W-1:0]  sdr_ba,
    output logic             sdr_cke,
    output logic             refresh_err
);

    mode_e           mode;
    state_e          state, state_nx;
    pins_t           dec_pins, pins_q, pins_o;
    logic [SA_W-1:0] dec_addr, addr_q;
    logic [BA_W-1:0] dec_ba, ba_q;
    logic            dpd_q, err_q, banks_idle, gap_last;
    logic            go_fire, exit_down, load_gap;

    sci_mode_reg u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mode_wr_en),
        .wr_data (mode_wr_data),
        .mode    (mode)
    );

    sci_cmd_decode #(.SA_W(SA_W), .BA_W(BA_W)) u_dec (
        .mode      (mode),
        .mode_word (host_addr[MW_W-1:0]),
        .pins      (dec_pins),
        .addr      (dec_addr),
        .ba        (dec_ba)
    );

    sci_gap_timer #(.GAP_W(GAP_W)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_gap),
        .load_val (gap_cycles),
        .last     (gap_last)
    );

    assign go_fire   = (state == ST_IDLE) && host_req && (mode != MD_NORMAL);
    assign exit_down = mode_wr_en && (mode_wr_data != MD_DEEP_PD) && (mode_wr_data != MD_RSVD);
    assign load_gap  = (state == ST_FIRE) && !dpd_q && (gap_cycles != '0);

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (go_fire) state_nx = ST_FIRE;
            ST_FIRE: begin
                if (dpd_q)                  state_nx = ST_DOWN;
                else if (gap_cycles == '0)  state_nx = ST_IDLE;
                else                        state_nx = ST_HOLD;
            end
            ST_HOLD: if (gap_last)  state_nx = ST_IDLE;
            ST_DOWN: if (exit_down) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register and command capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            pins_q     <= PINS_DESEL;
            addr_q     <= '0;
            ba_q       <= '0;
            dpd_q      <= 1'b0;
            err_q      <= 1'b0;
            banks_idle <= 1'b0;
        end else begin
            state <= state_nx;
            if (go_fire) begin
                pins_q <= dec_pins;
                addr_q <= dec_addr;
                ba_q   <= dec_ba;
                dpd_q  <= (mode == MD_DEEP_PD);
                err_q  <= (mode == MD_AUTO_REF) && !banks_idle;
                if (mode == MD_PRE_ALL) banks_idle <= 1'b1;
            end else if (eng_req && eng_ack) begin
                banks_idle <= 1'b0;
            end
        end
    end

    // output logic
    always_comb begin
        pins_o      = PINS_DESEL;
        sdr_addr    = '0;
        sdr_ba      = '0;
        sdr_cke     = 1'b1;
        host_ack    = 1'b0;
        eng_req     = 1'b0;
        refresh_err = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (mode == MD_NORMAL) begin
                    eng_req  = host_req;
                    host_ack = host_req && eng_ack;
                end
            end
            ST_FIRE: begin
                pins_o      = pins_q;
                sdr_addr    = addr_q;
                sdr_ba      = ba_q;
                host_ack    = 1'b1;
                refresh_err = err_q;
            end
            ST_HOLD: begin
                host_ack = 1'b0;
            end
            ST_DOWN: begin
                sdr_cke  = 1'b0;
                host_ack = host_req;
            end
            default: begin
                pins_o = PINS_DESEL;
            end
        endcase
    end

    assign eng_we    = host_we;
    assign eng_addr  = host_addr;
    assign sdr_cs_n  = pins_o.cs_n;
    assign sdr_ras_n = pins_o.ras_n;
    assign sdr_cas_n = pins_o.cas_n;
    assign sdr_we_n  = pins_o.we_n;

    AST_ENG_ONLY_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |-> (sdr_cs_n && mode == MD_NORMAL)); // R2

    AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !sdr_cs_n |=> sdr_cs_n); // R3

    AST_CMD_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
        !sdr_cs_n |-> host_ack); // R3

    AST_PRE_ADDR10: assert property (@(posedge clk) disable iff (!rst_n)
        ({sdr_cs_n, sdr_ras_n, sdr_cas_n, sdr_we_n} == 4'b0010) |-> sdr_addr[PRE_BIT]); // R4

    AST_ERR_WITH_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_err |-> ({sdr_cs_n, sdr_ras_n, sdr_cas_n, sdr_we_n} == 4'b0001)); // R8

    AST_CKE_AFTER_DPD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sdr_cke) |-> $past({sdr_cs_n, sdr_ras_n, sdr_cas_n, sdr_we_n} == 4'b0110)); // R10

endmodule

// File: tb/sdram_cmd_issuer_bench.sv
module sdram_cmd_issuer_bench;

    localparam int HA_W = 16;
    localparam int SA_W = 13;
    localparam int BA_W = 2;
    localparam int GAP_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mode_wr_en = 1'b0;
    logic [2:0]       mode_wr_data = '0;
    logic [GAP_W-1:0] gap_cycles = '0;
    logic             host_req = 1'b0;
    logic             host_we = 1'b0;
    logic [HA_W-1:0]  host_addr = '0;
    logic             host_ack;
    logic             eng_req, eng_we;
    logic [HA_W-1:0]  eng_addr;
    logic             eng_ack = 1'b0;
    logic             sdr_cs_n, sdr_ras_n, sdr_cas_n, sdr_we_n;
    logic [SA_W-1:0]  sdr_addr;
    logic [BA_W-1:0]  sdr_ba;
    logic             sdr_cke, refresh_err;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [15:0] addr_set [4] = '{16'h0000, 16'hFFFF, 16'h2A5C, 16'h5123};

    sdram_cmd_issuer u_sdram_cmd_issuer (
        .clk(clk), .rst_n(rst_n),
        .mode_wr_en(mode_wr_en), .mode_wr_data(mode_wr_data),
        .gap_cycles(gap_cycles),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_ack(host_ack),
        .eng_req(eng_req), .eng_we(eng_we), .eng_addr(eng_addr), .eng_ack(eng_ack),
        .sdr_cs_n(sdr_cs_n), .sdr_ras_n(sdr_ras_n), .sdr_cas_n(sdr_cas_n),
        .sdr_we_n(sdr_we_n), .sdr_addr(sdr_addr), .sdr_ba(sdr_ba),
        .sdr_cke(sdr_cke), .refresh_err(refresh_err)
    );

    always #4 clk = ~clk;

    function automatic logic [3:0] pins_now();
        return {sdr_cs_n, sdr_ras_n, sdr_cas_n, sdr_we_n};
    endfunction

    function automatic logic [3:0] exp_pins(input int m);
        case (m)
            1: return 4'b0111;
            2: return 4'b0010;
            3: return 4'b0000;
            4: return 4'b0001;
            5: return 4'b0000;
            6: return 4'b0110;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [SA_W-1:0] exp_addr(input int m, input logic [15:0] a);
        if (m == 2) return 13'h0400;
        if (m == 3 || m == 5) return a[12:0];
        return '0;
    endfunction

    function automatic logic [BA_W-1:0] exp_ba(input int m, input logic [15:0] a);
        if (m == 5) return a[14:13];
        return '0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_mode(input logic [2:0] m);
        @(negedge clk);
        mode_wr_en = 1'b1;
        mode_wr_data = m;
        @(negedge clk);
        mode_wr_en = 1'b0;
    endtask

    // raise a request, sample one edge later, then drop it
    task automatic fire(input logic we, input logic [15:0] a);
        @(negedge clk);
        host_req = 1'b1;
        host_we = we;
        host_addr = a;
        @(negedge clk);
    endtask

    task automatic release_req();
        host_req = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 cs_n", sdr_cs_n, 1);
        check("R1 cke", sdr_cke, 1);
        check("R1 ack", host_ack, 0);
        check("R1 eng_req", eng_req, 0);
        check("R1 err", refresh_err, 0);

        // R2 pass-through in the reset mode, several patterns
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            host_req = 1'b1;
            host_we = i[0];
            host_addr = addr_set[i];
            eng_ack = 1'b0;
            #1;
            check("R2 eng_req", eng_req, 1);
            check("R2 eng_we", eng_we, i[0]);
            check("R2 eng_addr", eng_addr, addr_set[i]);
            check("R2 ack wait", host_ack, 0);
            check("R2 pins", pins_now(), 4'b1111);
            eng_ack = 1'b1;
            #1;
            check("R2 ack", host_ack, 1);
            @(negedge clk);
            host_req = 1'b0;
            eng_ack = 1'b0;
        end

        // R3 R4 R5 R6 sweep of forced modes
        for (int m = 1; m <= 5; m++) begin
            write_mode(3'(m));
            check("R6 no cmd on mode write", sdr_cs_n, 1);
            for (int we = 0; we < 2; we++) begin
                for (int k = 0; k < 4; k++) begin
                    fire(we[0], addr_set[k]);
                    check("R3 pins", pins_now(), exp_pins(m));
                    check("R3 ack", host_ack, 1);
                    check("R4 R5 addr", sdr_addr, exp_addr(m, addr_set[k]));
                    check("R5 ba", sdr_ba, exp_ba(m, addr_set[k]));
                    check("R3 no engine", eng_req, 0);
                    release_req();
                    @(negedge clk);
                    check("R3 one cycle", sdr_cs_n, 1);
                end
            end
        end

        // R7 reserved mode ignored
        write_mode(3'd1);
        write_mode(3'd7);
        fire(1'b1, 16'h1234);
        check("R7 still nop", pins_now(), 4'b0111);
        release_req();
        write_mode(3'd0);
        write_mode(3'd7);
        @(negedge clk);
        host_req = 1'b1;
        eng_ack = 1'b1;
        #1;
        check("R7 still normal", eng_req, 1);
        check("R7 pins idle", pins_now(), 4'b1111);
        @(negedge clk);
        host_req = 1'b0;
        eng_ack = 1'b0;

        // R8 refresh error tracking (a handshake just completed: banks open)
        write_mode(3'd4);
        fire(1'b0, 16'h0);
        check("R8 err open", refresh_err, 1);
        release_req();
        @(negedge clk);
        check("R8 err one cycle", refresh_err, 0);
        write_mode(3'd2);
        fire(1'b0, 16'h0);
        check("R8 no err on precharge", refresh_err, 0);
        release_req();
        write_mode(3'd4);
        fire(1'b1, 16'h0);
        check("R8 err closed", refresh_err, 0);
        release_req();
        fire(1'b1, 16'h0);
        check("R8 err second refresh", refresh_err, 0);
        release_req();
        write_mode(3'd0);
        @(negedge clk);
        host_req = 1'b1;
        eng_ack = 1'b1;
        @(negedge clk);
        host_req = 1'b0;
        eng_ack = 1'b0;
        write_mode(3'd4);
        fire(1'b0, 16'h0);
        check("R8 err reopened", refresh_err, 1);
        release_req();

        // R9 hold-off sweep
        write_mode(3'd1);
        for (int g = 0; g < 16; g++) begin
            int cnt;
            int guard;
            gap_cycles = 4'(g);
            @(negedge clk);
            host_req = 1'b1;
            guard = 0;
            do begin
                @(negedge clk);
                guard++;
            end while (!host_ack && guard < 40);
            cnt = 0;
            do begin
                @(negedge clk);
                cnt++;
            end while (!host_ack && cnt < 40);
            check("R9 ack spacing", cnt, g + 2);
            host_req = 1'b0;
            repeat (g + 3) @(negedge clk);
        end
        gap_cycles = '0;

        // R10 deep power-down
        write_mode(3'd6);
        check("R10 cke before", sdr_cke, 1);
        fire(1'b0, 16'h0);
        check("R10 dpd pins", pins_now(), 4'b0110);
        check("R10 cke during cmd", sdr_cke, 1);
        release_req();
        @(negedge clk);
        check("R10 cke low", sdr_cke, 0);
        check("R10 desel", sdr_cs_n, 1);
        host_req = 1'b1;
        #1;
        check("R10 ack while down", host_ack, 1);
        check("R10 no cmd while down", pins_now(), 4'b1111);
        @(negedge clk);
        host_req = 1'b0;
        write_mode(3'd7);
        check("R10 R7 stays down", sdr_cke, 0);
        write_mode(3'd6);
        check("R10 mode 6 stays down", sdr_cke, 0);
        write_mode(3'd1);
        check("R10 exit cke", sdr_cke, 1);
        fire(1'b1, 16'h0);
        check("R10 after exit", pins_now(), 4'b0111);
        release_req();
        @(negedge clk);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule